// File: doc/BRIEF.md
# Frame Buffer Address Generator

This block produces the word addresses used to store image frames in an external SDRAM and to fetch them back. The SDRAM holds a small number of frame slots and is run as a ring: a write pointer fills one slot while a read pointer drains an older one, so the memory behaves as a FIFO whose entries are whole frames. Each line starts on a 4096-word boundary and each frame slot on a 4096-line boundary, so an address is the concatenation of slot index, line index and word index, with no multiplier.

Each side moves one burst of eight 16-bit words (one 128-bit host access) per accepted step. The word index of the final burst of a line may run past the active line end; that burst is still issued, with a lane mask that disables the words beyond the line. Two line lengths are supported: pad mode stores one pixel per word (the line is as long as the image is wide), and packed mode stores four 12-bit pixels in three words (three quarters of the width). The mode input may change only while both pointers sit at the start of a frame.

A frame counter counts frames that are complete and not yet read. Writing is refused while every slot is full and reading is refused while no complete frame is stored. With default parameters the image is 3664 pixels by 2748 lines and three slots are used.

Top module: `frame_addr_gen`

## Requirements
- R1: After reset both addresses are zero, the frame count is zero, write is allowed, read is refused, and the write lane mask is all ones.
- R2: An address is {slot, line, word}: the slot index in bits 25:24, the line index in bits 23:12 and the word index in bits 11:0.
- R3: Each accepted step moves the word index of its side up by 8 while the line is not finished.
- R4: A line holds ACT_W words in pad mode (pack_mode = 0) and ACT_W*3/4 words in packed mode (pack_mode = 1); after the burst that reaches the line end, the word index returns to 0 and the line index increases by 1.
- R5: Bit i of a lane mask is 1 exactly when word index + i is below the line length; bit 0 is the lowest word of the burst.
- R6: After the last burst of line ACT_H-1, the line index returns to 0 and the slot index steps 0, 1, 2 and back to 0.
- R7: The frame count rises by one when a write frame ends, falls by one when a read frame ends, and stays unchanged when both end in the same cycle; it is shown on frames_stored.
- R8: While frames_stored equals the slot count, wr_ok is low and wr_step leaves the write address unchanged.
- R9: While frames_stored is zero, rd_ok is low and rd_step leaves the read address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_mode | input | 1 | 1 = packed line length, 0 = pad line length |
| wr_step | input | 1 | Write burst issued this cycle (takes effect only when wr_ok) |
| wr_ok | output | 1 | A free slot exists for writing |
| wr_addr | output | 26 | Word address of the current write burst |
| wr_mask | output | 8 | Lane enables of the current write burst |
| rd_step | input | 1 | Read burst issued this cycle (takes effect only when rd_ok) |
| rd_ok | output | 1 | A complete frame is stored |
| rd_addr | output | 26 | Word address of the current read burst |
| rd_mask | output | 8 | Lane enables of the current read burst |
| frames_stored | output | 2 | Complete frames written and not yet read |

## Verification
A wrong pointer shows at the address port on the very burst it affects, because every address is compared with an independent model as soon as its step is accepted; a bad line length or mask appears at the last burst of the first line. A wrong frame count stays hidden until it crosses zero or the slot count, so the bench drives the buffer full and empty, runs a write frame and a read frame that finish in the same cycle, and probes a step against each refused side, where a bad count shows as a moving address or a wrong ok flag within one cycle.

// File: rtl/frame_addr_pkg.sv
package frame_addr_pkg;

    localparam int SLOT_W      = 2;
    localparam int LINE_W      = 12;
    localparam int WORD_W      = 12;
    localparam int ADDR_W      = SLOT_W + LINE_W + WORD_W;
    localparam int BURST_WORDS = 8;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [LINE_W-1:0] line;
        logic [WORD_W-1:0] word;
    } fb_ptr_t;

    // Lanes enabled for a burst with 'remaining' words left in the line.
    function automatic logic [BURST_WORDS-1:0] lane_mask(input logic [WORD_W:0] remaining);
        logic [BURST_WORDS-1:0] m;
        for (int i = 0; i < BURST_WORDS; i++) begin
            m[i] = ((WORD_W+1)'(i) < remaining);
        end
        return m;
    endfunction

endpackage

// File: rtl/fag_walker.sv
module fag_walker
    import frame_addr_pkg::*;
#(
    parameter int ACT_H     = 2748,
    parameter int NUM_SLOTS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step,
    input  logic [WORD_W:0]        line_words,
    output fb_ptr_t                ptr,
    output logic [BURST_WORDS-1:0] mask,
    output logic                   frame_last
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(ACT_H - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [WORD_W:0] word_after;
    logic            line_end;
    logic            line_last;

    always_comb begin
        word_after = {1'b0, ptr.word} + (WORD_W+1)'(BURST_WORDS);
        line_end   = (word_after >= line_words);
        line_last  = (ptr.line == LAST_LINE);
        frame_last = line_end && line_last;
        mask       = lane_mask(line_words - {1'b0, ptr.word});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            if (!line_end) begin
                ptr.word <= word_after[WORD_W-1:0];
            end else begin
                ptr.word <= '0;
                if (!line_last) begin
                    ptr.line <= ptr.line + 1'b1;
                end else begin
                    ptr.line <= '0;
                    ptr.slot <= (ptr.slot == LAST_SLOT) ? '0 : ptr.slot + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fag_occupancy.sv
module fag_occupancy #(
    parameter int NUM_SLOTS = 3,
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_done,
    input  logic             rd_done,
    output logic [CNT_W-1:0] count,
    output logic             has_room,
    output logic             has_frame
);

    always_comb begin
        has_room  = (count < CNT_W'(NUM_SLOTS));
        has_frame = (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({wr_done, rd_done})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen
    import frame_addr_pkg::*;
#(
    parameter int ACT_W     = 3664,
    parameter int ACT_H     = 2748,
    parameter int NUM_SLOTS = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              pack_mode,
    input  logic                              wr_step,
    output logic                              wr_ok,
    output logic [ADDR_W-1:0]                 wr_addr,
    output logic [BURST_WORDS-1:0]            wr_mask,
    input  logic                              rd_step,
    output logic                              rd_ok,
    output logic [ADDR_W-1:0]                 rd_addr,
    output logic [BURST_WORDS-1:0]            rd_mask,
    output logic [$clog2(NUM_SLOTS+1)-1:0]    frames_stored
);

    localparam int PACK_WORDS = ACT_W * 3 / 4;
    localparam int SIDES      = 2;

    logic [WORD_W:0] line_words;
    logic [SIDES-1:0] side_step;
    logic [SIDES-1:0] side_last;
    fb_ptr_t          side_ptr  [SIDES];
    logic [BURST_WORDS-1:0] side_mask [SIDES];

    assign line_words = pack_mode ? (WORD_W+1)'(PACK_WORDS) : (WORD_W+1)'(ACT_W);
    assign side_step  = {rd_step && rd_ok, wr_step && wr_ok};

    // index 0 = write side, index 1 = read side
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        fag_walker #(
            .ACT_H     (ACT_H),
            .NUM_SLOTS (NUM_SLOTS)
        ) u_walk (
            .clk        (clk),
            .rst        (rst),
            .step       (side_step[s]),
            .line_words (line_words),
            .ptr        (side_ptr[s]),
            .mask       (side_mask[s]),
            .frame_last (side_last[s])
        );
    end

    fag_occupancy #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_occ (
        .clk       (clk),
        .rst       (rst),
        .wr_done   (side_step[0] && side_last[0]),
        .rd_done   (side_step[1] && side_last[1]),
        .count     (frames_stored),
        .has_room  (wr_ok),
        .has_frame (rd_ok)
    );

    assign wr_addr = side_ptr[0];
    assign wr_mask = side_mask[0];
    assign rd_addr = side_ptr[1];
    assign rd_mask = side_mask[1];

endmodule

// File: rtl/frame_addr_chk.sv
module frame_addr_chk #(
    parameter int ACT_W     = 3664,
    parameter int ACT_H     = 2748,
    parameter int NUM_SLOTS = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           pack_mode,
    input logic                           wr_step,
    input logic                           wr_ok,
    input logic [25:0]                    wr_addr,
    input logic [7:0]                     wr_mask,
    input logic                           rd_step,
    input logic                           rd_ok,
    input logic [25:0]                    rd_addr,
    input logic [7:0]                     rd_mask,
    input logic [$clog2(NUM_SLOTS+1)-1:0] frames_stored
);

    localparam int PACK_WORDS = ACT_W * 3 / 4;
    logic [12:0] len;
    assign len = pack_mode ? 13'(PACK_WORDS) : 13'(ACT_W);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (wr_addr == '0 && rd_addr == '0 && frames_stored == '0));

    // R3
    wr_word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_step && wr_ok && ({1'b0, wr_addr[11:0]} + 13'd8 < len))
        |=> wr_addr[11:0] == $past(wr_addr[11:0]) + 12'd8);

    // R3
    rd_word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_step && rd_ok && ({1'b0, rd_addr[11:0]} + 13'd8 < len))
        |=> rd_addr[11:0] == $past(rd_addr[11:0]) + 12'd8);

    // R5
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mask[0] && rd_mask[0] &&
        ((wr_mask & (wr_mask + 8'd1)) == 8'd0) &&
        ((rd_mask & (rd_mask + 8'd1)) == 8'd0));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        frames_stored <= NUM_SLOTS);

    // R7
    count_delta_chk: assert property (@(posedge clk) disable iff (rst)
        (frames_stored == $past(frames_stored)) ||
        (frames_stored == $past(frames_stored) + 1) ||
        (frames_stored + 1 == $past(frames_stored)));

    // R8
    wr_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_step && !wr_ok) |=> $stable(wr_addr));

    // R9
    rd_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !rd_ok) |=> $stable(rd_addr));

    // R8
    wr_ok_full_chk: assert property (@(posedge clk) disable iff (rst)
        (frames_stored == NUM_SLOTS) |-> !wr_ok);

    // R9
    rd_ok_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (frames_stored == 0) |-> !rd_ok);

endmodule

bind frame_addr_gen frame_addr_chk #(
    .ACT_W     (ACT_W),
    .ACT_H     (ACT_H),
    .NUM_SLOTS (NUM_SLOTS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pack_mode     (pack_mode),
    .wr_step       (wr_step),
    .wr_ok         (wr_ok),
    .wr_addr       (wr_addr),
    .wr_mask       (wr_mask),
    .rd_step       (rd_step),
    .rd_ok         (rd_ok),
    .rd_addr       (rd_addr),
    .rd_mask       (rd_mask),
    .frames_stored (frames_stored)
);

// File: tb/sim_frame_addr_gen.sv
module sim_frame_addr_gen;

    localparam int TW = 20;
    localparam int TH = 3;
    localparam int TS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pack_mode = 1'b0;
    logic        wr_step = 1'b0;
    logic        rd_step = 1'b0;
    logic        wr_ok, rd_ok;
    logic [25:0] wr_addr, rd_addr;
    logic [7:0]  wr_mask, rd_mask;
    logic [1:0]  frames_stored;

    always #4 clk = ~clk;

    frame_addr_gen #(.ACT_W(TW), .ACT_H(TH), .NUM_SLOTS(TS)) u0 (
        .clk(clk), .rst(rst), .pack_mode(pack_mode),
        .wr_step(wr_step), .wr_ok(wr_ok), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .rd_step(rd_step), .rd_ok(rd_ok), .rd_addr(rd_addr), .rd_mask(rd_mask),
        .frames_stored(frames_stored)
    );

    int checks = 0;
    int errors = 0;
    bit probe  = 1'b0;

    logic [33:0] wq[$];
    logic [33:0] rq[$];

    int ws = 0, wl = 0, ww = 0;
    int rs = 0, rl = 0, rw = 0;
    int mcnt = 0;

    function automatic int line_len();
        return pack_mode ? (TW * 3 / 4) : TW;
    endfunction

    function automatic logic [33:0] expect_item(int s, int l, int w);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (w + i < line_len());
        return {2'(s), 12'(l), 12'(w), m};
    endfunction

    task automatic check(string req, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic advance(inout int s, inout int l, inout int w, output bit done);
        done = 1'b0;
        w += 8;
        if (w >= line_len()) begin
            w = 0;
            if (l == TH - 1) begin
                l = 0;
                s = (s + 1) % TS;
                done = 1'b1;
            end else begin
                l++;
            end
        end
    endtask

    // driver: pushes what each accepted burst must look like
    task automatic step(bit w, bit r);
        bit d;
        @(negedge clk);
        wr_step = w;
        rd_step = r;
        if (w) begin
            wq.push_back(expect_item(ws, wl, ww));
            advance(ws, wl, ww, d);
            if (d) mcnt++;
        end
        if (r) begin
            rq.push_back(expect_item(rs, rl, rw));
            advance(rs, rl, rw, d);
            if (d) mcnt--;
        end
    endtask

    task automatic idle_check_count();
        @(negedge clk);
        wr_step = 1'b0;
        rd_step = 1'b0;
        #2;
        check("R7 frames_stored", 34'(frames_stored), 34'(mcnt));
        check("R8 wr_ok", 34'(wr_ok), 34'(mcnt < TS));
        check("R9 rd_ok", 34'(rd_ok), 34'(mcnt > 0));
    endtask

    task automatic frames(bit w, bit r, int n);
        int per;
        per = TH * ((line_len() + 7) / 8);
        for (int i = 0; i < n * per; i++) step(w, r);
        idle_check_count();
    endtask

    // monitor: pops expectations as bursts are accepted
    always @(negedge clk) begin
        #2;
        if (!rst && !probe) begin
            if (wr_step) begin
                if (!wr_ok) begin
                    checks++; errors++;
                    $display("FAIL R8 write refused actual=0 expected=1");
                end else if (wq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 write queue empty actual=none expected=item");
                end else begin
                    check("R2 R3 R4 R5 R6 write addr/mask", {wr_addr, wr_mask}, wq.pop_front());
                end
            end
            if (rd_step) begin
                if (!rd_ok) begin
                    checks++; errors++;
                    $display("FAIL R9 read refused actual=0 expected=1");
                end else if (rq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 read queue empty actual=none expected=item");
                end else begin
                    check("R2 R3 R4 R5 R6 read addr/mask", {rd_addr, rd_mask}, rq.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [25:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1
        check("R1 reset wr_addr", 34'(wr_addr), 34'd0);
        check("R1 reset rd_addr", 34'(rd_addr), 34'd0);
        check("R1 reset count", 34'(frames_stored), 34'd0);
        check("R1 reset ok flags", 34'({wr_ok, rd_ok}), 34'b10);
        check("R1 reset wr_mask", 34'(wr_mask), 34'hFF);

        // R9: read refused on empty buffer
        probe = 1'b1;
        @(negedge clk); rd_step = 1'b1; held = rd_addr;
        @(negedge clk); rd_step = 1'b0; #2;
        check("R9 empty read addr held", 34'(rd_addr), 34'(held));
        check("R9 empty rd_ok", 34'(rd_ok), 34'd0);
        probe = 1'b0;

        // pad mode: fill all slots one frame at a time (R4 R5 R6 R7)
        frames(1'b1, 1'b0, 1);
        frames(1'b1, 1'b0, 1);
        frames(1'b1, 1'b0, 1);

        // R8: write refused when full
        probe = 1'b1;
        @(negedge clk); wr_step = 1'b1; held = wr_addr;
        @(negedge clk); wr_step = 1'b0; #2;
        check("R8 full write addr held", 34'(wr_addr), 34'(held));
        check("R8 full wr_ok", 34'(wr_ok), 34'd0);
        probe = 1'b0;

        frames(1'b0, 1'b1, 1);
        // R7: write frame and read frame end in the same cycle
        frames(1'b1, 1'b1, 1);
        check("R7 simultaneous ends", 34'(frames_stored), 34'd2);
        frames(1'b0, 1'b1, 2);
        check("R6 read slot wrapped", 34'(rd_addr[25:24]), 34'd1);

        // packed mode, both pointers at frame start
        pack_mode = 1'b1;
        frames(1'b1, 1'b0, 2);
        frames(1'b0, 1'b1, 2);
        check("R6 write slot after wrap", 34'(wr_addr[25:24]), 34'd0);
        check("R2 queues drained", 34'(wq.size() + rq.size()), 34'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule